// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits at the home node of a small distributed shared-memory system. It keeps, for every memory block it owns, a directory entry: a coherence state (Uncached, Shared or Exclusive) and a presence vector with one bit per processor. Caches send it miss and write-back requests over a valid/ready request channel. It answers with point-to-point messages on a valid/ready output channel. No broadcast medium exists, so each request turns into an ordered series of single-destination messages.

The controller handles one request at a time, in arrival order. A write miss to a shared block first invalidates the other holders one by one and then answers the requester. A miss to an exclusively held block asks the owner for its data and parks until the owner's write-back arrives on the request channel. It then refreshes the backing store and answers the requester. The backing store is a small array inside the block, cleared at reset.

Top module: `coh_home_dir`

## Requirements
- R1: After synchronous active-high reset, every block is Uncached with an empty presence vector, every memory word is zero, `out_valid` is low and `req_ready` is high.
- R2: A read miss (`req_kind` 0) from P to an Uncached block produces one data reply (`out_kind` 3) to P carrying the stored word, and leaves the block Shared with P as its only holder.
- R3: A write miss (`req_kind` 1) from P to an Uncached block produces one data reply to P with the stored word, and leaves the block Exclusive with owner P.
- R4: A read miss from P to a Shared block produces one data reply to P from memory and adds P to the holders, keeping the existing ones.
- R5: A write miss from P to a Shared block sends an invalidate (`out_kind` 0) to every holder other than P, one message per handshake in ascending processor number, then a data reply to P. The block becomes Exclusive with owner P. If P is the only holder, only the reply is sent.
- R6: A read miss from P to an Exclusive block sends a fetch (`out_kind` 1) to the owner. The owner's write-back (`req_kind` 2, same address, source = owner) is written to memory and returned to P in the data reply. The block becomes Shared with both the old owner and P as holders.
- R7: A write miss from P to an Exclusive block sends a fetch-and-invalidate (`out_kind` 2) to the owner. The owner's write-back data is stored and returned to P. The block stays Exclusive with owner P.
- R8: A write-back accepted while idle stores `req_data`, makes the block Uncached with an empty presence vector, and emits no message.
- R9: While any message of a transaction is pending, `req_ready` is low. While waiting for owner data, `req_ready` is low for every request except a write-back from that owner to that address.
- R10: While `out_valid` is high and `out_ready` is low, the output message (`out_kind`, `out_dst`, `out_addr`, `out_data`) holds steady and `out_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 dropped |
| req_src | input | PW | Sending processor number |
| req_addr | input | AW | Block number |
| req_data | input | DW | Block value (write-back only) |
| out_valid | output | 1 | Message present |
| out_ready | input | 1 | Message taken this cycle |
| out_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| out_dst | output | PW | Destination processor number |
| out_addr | output | AW | Block number |
| out_data | output | DW | Block value for a data reply, zero otherwise |

## Verification
The bench builds the controller with five processors, four blocks and 16-bit data. Five processors give a non-power-of-two processor field and invalidate chains of up to four messages with gaps in the holder set. Four blocks make random traffic return to the same blocks often, so every pairing of state and request comes up many times, including owner self-reads and upgrades by a current holder. Random back-pressure on the output channel and wrong requests offered during owner waits exercise the stall rules.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    localparam int MAX_PROC = 64;

    typedef enum logic [1:0] {
        DIR_UNCACHED = 2'd0,
        DIR_SHARED   = 2'd1,
        DIR_EXCL     = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        REQ_RD_MISS = 2'd0,
        REQ_WR_MISS = 2'd1,
        REQ_WBACK   = 2'd2,
        REQ_RSVD    = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        MSG_INVAL     = 2'd0,
        MSG_FETCH     = 2'd1,
        MSG_FETCH_INV = 2'd2,
        MSG_DATA      = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        CTL_IDLE  = 3'd0,
        CTL_INVAL = 3'd1,
        CTL_FETCH = 3'd2,
        CTL_WAIT  = 3'd3,
        CTL_REPLY = 3'd4
    } ctl_state_e;

    // index of the lowest set bit, zero when the vector is empty
    function automatic logic [5:0] lowest_one(input logic [MAX_PROC-1:0] vec);
        logic [5:0] idx;
        idx = '0;
        for (int i = MAX_PROC - 1; i >= 0; i--) begin
            if (vec[i]) idx = 6'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/coh_dir_table.sv
module coh_dir_table
    import coh_dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    parameter int AW    = 3
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_addr,
    output dir_state_e       rd_state,
    output logic [NPROC-1:0] rd_holders,
    output logic [DW-1:0]    rd_word,
    input  logic [AW-1:0]    wr_addr,
    input  logic             dir_we,
    input  dir_state_e       dir_state_in,
    input  logic [NPROC-1:0] dir_holders_in,
    input  logic             mem_we,
    input  logic [DW-1:0]    mem_word_in
);

    dir_state_e       st_q   [NBLK];
    logic [NPROC-1:0] hold_q [NBLK];
    logic [DW-1:0]    word_q [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_entry
        logic hit;
        assign hit = (wr_addr == AW'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[b]   <= DIR_UNCACHED;
                hold_q[b] <= '0;
                word_q[b] <= '0;
            end else begin
                if (dir_we && hit) begin
                    st_q[b]   <= dir_state_in;
                    hold_q[b] <= dir_holders_in;
                end
                if (mem_we && hit) begin
                    word_q[b] <= mem_word_in;
                end
            end
        end
    end

    assign rd_state   = st_q[rd_addr];
    assign rd_holders = hold_q[rd_addr];
    assign rd_word    = word_q[rd_addr];

endmodule

// File: rtl/coh_inval_seq.sv
module coh_inval_seq
    import coh_dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int PW    = 2
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NPROC-1:0] load_mask,
    input  logic             step,
    output logic [PW-1:0]    cur_dst,
    output logic             last
);

    logic [NPROC-1:0] mask_q;
    logic [NPROC-1:0] rest;

    // drop the lowest pending target
    assign rest    = mask_q & (mask_q - NPROC'(1));
    assign last    = (rest == '0);
    assign cur_dst = PW'(lowest_one(MAX_PROC'(mask_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= load_mask;
        end else if (step) begin
            mask_q <= rest;
        end
    end

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
    import coh_dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 16,
    localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [PW-1:0] req_src,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [1:0]    out_kind,
    output logic [PW-1:0] out_dst,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);

    ctl_state_e       cs_q, cs_d;
    req_kind_e        kind_q, kind_in;
    logic [PW-1:0]    src_q, owner_q, owner_idx, seq_dst;
    logic [AW-1:0]    addr_q, look_addr;
    dir_state_e       cur_st, new_st;
    logic [NPROC-1:0] cur_hold, new_hold, req_bit, held_bit, seq_mask;
    logic [DW-1:0]    cur_word;
    logic             dir_we, mem_we, seq_load, seq_last;
    logic             take_new, wb_match, out_fire;

    assign kind_in   = req_kind_e'(req_kind);
    assign req_bit   = NPROC'(1) << req_src;
    assign held_bit  = NPROC'(1) << src_q;
    assign look_addr = (cs_q == CTL_IDLE) ? req_addr : addr_q;
    assign owner_idx = PW'(lowest_one(MAX_PROC'(cur_hold)));

    assign take_new  = (cs_q == CTL_IDLE) && req_valid;
    assign wb_match  = req_valid && (kind_in == REQ_WBACK) &&
                       (req_src == owner_q) && (req_addr == addr_q);
    assign req_ready = (cs_q == CTL_IDLE) || ((cs_q == CTL_WAIT) && wb_match);
    assign out_fire  = out_valid && out_ready;

    coh_dir_table #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW), .AW(AW)) table_i (
        .clk            (clk),
        .rst            (rst),
        .rd_addr        (look_addr),
        .rd_state       (cur_st),
        .rd_holders     (cur_hold),
        .rd_word        (cur_word),
        .wr_addr        (look_addr),
        .dir_we         (dir_we),
        .dir_state_in   (new_st),
        .dir_holders_in (new_hold),
        .mem_we         (mem_we),
        .mem_word_in    (req_data)
    );

    coh_inval_seq #(.NPROC(NPROC), .PW(PW)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .load      (seq_load),
        .load_mask (seq_mask),
        .step      (out_fire && (cs_q == CTL_INVAL)),
        .cur_dst   (seq_dst),
        .last      (seq_last)
    );

    always_comb begin
        cs_d     = cs_q;
        dir_we   = 1'b0;
        mem_we   = 1'b0;
        new_st   = cur_st;
        new_hold = cur_hold;
        seq_load = 1'b0;
        seq_mask = '0;
        unique case (cs_q)
            CTL_IDLE: begin
                if (take_new) begin
                    unique case (kind_in)
                        REQ_WBACK: begin
                            mem_we   = 1'b1;
                            dir_we   = 1'b1;
                            new_st   = DIR_UNCACHED;
                            new_hold = '0;
                        end
                        REQ_RD_MISS: begin
                            if (cur_st == DIR_EXCL) begin
                                cs_d = CTL_FETCH;
                            end else begin
                                dir_we   = 1'b1;
                                new_st   = DIR_SHARED;
                                new_hold = ((cur_st == DIR_SHARED) ? cur_hold : '0) | req_bit;
                                cs_d     = CTL_REPLY;
                            end
                        end
                        REQ_WR_MISS: begin
                            if (cur_st == DIR_EXCL) begin
                                cs_d = CTL_FETCH;
                            end else begin
                                dir_we   = 1'b1;
                                new_st   = DIR_EXCL;
                                new_hold = req_bit;
                                seq_load = 1'b1;
                                seq_mask = (cur_st == DIR_SHARED) ? (cur_hold & ~req_bit) : '0;
                                cs_d     = (|seq_mask) ? CTL_INVAL : CTL_REPLY;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            CTL_INVAL: if (out_fire && seq_last) cs_d = CTL_REPLY;
            CTL_FETCH: if (out_fire) cs_d = CTL_WAIT;
            CTL_WAIT: begin
                if (wb_match) begin
                    mem_we = 1'b1;
                    dir_we = 1'b1;
                    cs_d   = CTL_REPLY;
                    if (kind_q == REQ_RD_MISS) begin
                        new_st   = DIR_SHARED;
                        new_hold = cur_hold | held_bit;
                    end else begin
                        new_st   = DIR_EXCL;
                        new_hold = held_bit;
                    end
                end
            end
            CTL_REPLY: if (out_fire) cs_d = CTL_IDLE;
            default:   cs_d = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= CTL_IDLE;
            kind_q  <= REQ_RD_MISS;
            src_q   <= '0;
            owner_q <= '0;
            addr_q  <= '0;
        end else begin
            cs_q <= cs_d;
            if (take_new) begin
                kind_q  <= kind_in;
                src_q   <= req_src;
                owner_q <= owner_idx;
                addr_q  <= req_addr;
            end
        end
    end

    always_comb begin
        out_valid = (cs_q == CTL_INVAL) || (cs_q == CTL_FETCH) || (cs_q == CTL_REPLY);
        out_addr  = addr_q;
        out_data  = '0;
        out_kind  = MSG_DATA;
        out_dst   = src_q;
        unique case (cs_q)
            CTL_INVAL: begin
                out_kind = MSG_INVAL;
                out_dst  = seq_dst;
            end
            CTL_FETCH: begin
                out_kind = (kind_q == REQ_WR_MISS) ? MSG_FETCH_INV : MSG_FETCH;
                out_dst  = owner_q;
            end
            CTL_REPLY: out_data = cur_word;
            default: ;
        endcase
    end

endmodule

// File: rtl/coh_home_dir_chk.sv
module coh_home_dir_chk
    import coh_dir_pkg::*;
#(
    parameter int PW = 2,
    parameter int AW = 3,
    parameter int DW = 16
)(
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [1:0]    out_kind,
    input logic [PW-1:0] out_dst,
    input logic [AW-1:0] out_addr,
    input logic [DW-1:0] out_data
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && req_ready));

    assert_reply_ends_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_kind == MSG_DATA) |=> !out_valid);

    assert_inval_ascending_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_kind == MSG_INVAL) |=>
        (!(out_valid && out_kind == MSG_INVAL) || (out_dst > $past(out_dst))));

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready);

    assert_msg_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_kind) && $stable(out_dst) &&
         $stable(out_addr) && $stable(out_data)));

endmodule

bind coh_home_dir coh_home_dir_chk #(.PW(PW), .AW(AW), .DW(DW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_kind  (out_kind),
    .out_dst   (out_dst),
    .out_addr  (out_addr),
    .out_data  (out_data)
);

// File: tb/coh_home_dir_tb_top.sv
`timescale 1ns/1ps
module coh_home_dir_tb_top;

    localparam int NPROC = 5;
    localparam int NBLK  = 4;
    localparam int DW    = 16;
    localparam int PW    = 3;
    localparam int AW    = 2;
    localparam int MAXM  = NPROC + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_ready;
    logic [1:0]    req_kind = '0;
    logic [PW-1:0] req_src = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          out_valid, out_ready = 1'b0;
    logic [1:0]    out_kind;
    logic [PW-1:0] out_dst;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;

    always #2.5 clk = ~clk;

    coh_home_dir #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_dst(out_dst), .out_addr(out_addr), .out_data(out_data)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // reference model: 0 uncached, 1 shared, 2 exclusive
    int               m_st   [NBLK];
    logic [NPROC-1:0] m_hold [NBLK];
    logic [DW-1:0]    m_mem  [NBLK];

    int            e_n;
    int            e_kind [MAXM];
    int            e_dst  [MAXM];
    logic [DW-1:0] e_data [MAXM];
    string         e_tag;

    int            g_kind, g_dst, g_addr;
    logic [DW-1:0] g_data;

    task automatic check(input bit ok, input string tag, input string info);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, info);
        end
    endtask

    function automatic int lowest(input logic [NPROC-1:0] v);
        for (int i = 0; i < NPROC; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic push(input int k, input int d, input logic [DW-1:0] v);
        e_kind[e_n] = k;
        e_dst[e_n]  = d;
        e_data[e_n] = v;
        e_n++;
    endtask

    task automatic predict(input int k, input int p, input int a, input logic [DW-1:0] wbv);
        logic [NPROC-1:0] pb;
        int o;
        pb  = NPROC'(1) << p;
        o   = lowest(m_hold[a]);
        e_n = 0;
        if (k == 2) begin
            e_tag = "R8";
            m_mem[a] = wbv; m_st[a] = 0; m_hold[a] = '0;
        end else if (m_st[a] == 2) begin
            e_tag = (k == 0) ? "R6" : "R7";
            push((k == 0) ? 1 : 2, o, '0);
            m_mem[a] = wbv;
            push(3, p, wbv);
            if (k == 0) begin m_st[a] = 1; m_hold[a] = m_hold[a] | pb; end
            else        begin m_st[a] = 2; m_hold[a] = pb; end
        end else if (k == 0) begin
            e_tag = (m_st[a] == 0) ? "R2" : "R4";
            push(3, p, m_mem[a]);
            m_hold[a] = ((m_st[a] == 1) ? m_hold[a] : '0) | pb;
            m_st[a] = 1;
        end else begin
            e_tag = (m_st[a] == 0) ? "R3" : "R5";
            if (m_st[a] == 1)
                for (int i = 0; i < NPROC; i++)
                    if (m_hold[a][i] && i != p) push(0, i, '0);
            push(3, p, m_mem[a]);
            m_st[a] = 2; m_hold[a] = pb;
        end
    endtask

    task automatic send_req(input int k, input int p, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(k); req_src = PW'(p);
        req_addr = AW'(a); req_data = d;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic get_msg();
        bit held_v;
        int hk, hd, ha;
        logic [DW-1:0] hdat;
        held_v = 1'b0;
        forever begin
            out_ready = ($urandom_range(0, 3) != 0);
            #1;
            if (held_v) begin
                check(out_valid && out_kind == 2'(hk) && out_dst == PW'(hd) &&
                      out_addr == AW'(ha) && out_data == hdat, "R10",
                      $sformatf("held msg changed: kind %0d dst %0d data %h, expected kind %0d dst %0d data %h",
                                out_kind, out_dst, out_data, hk, hd, hdat));
                held_v = 1'b0;
            end
            if (out_valid && out_ready) begin
                g_kind = int'(out_kind); g_dst = int'(out_dst);
                g_addr = int'(out_addr); g_data = out_data;
                @(negedge clk);
                break;
            end
            if (out_valid) begin
                held_v = 1'b1;
                hk = int'(out_kind); hd = int'(out_dst); ha = int'(out_addr); hdat = out_data;
            end
            @(negedge clk);
        end
    endtask

    task automatic probe_stall(input int a, input int p, input int owner);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_src = PW'(p); req_addr = AW'(a);
        #1;
        check(!req_ready, "R9", $sformatf("read taken while waiting for owner: ready %0d expected 0", req_ready));
        @(negedge clk);
        req_kind = 2'd2; req_src = PW'((owner + 1) % NPROC);
        #1;
        check(!req_ready, "R9", $sformatf("foreign write-back taken: ready %0d expected 0", req_ready));
        @(negedge clk);
        req_src = PW'(owner); req_addr = AW'((a + 1) % NBLK);
        #1;
        check(!req_ready, "R9", $sformatf("other-address write-back taken: ready %0d expected 0", req_ready));
        req_valid = 1'b0;
    endtask

    task automatic run_txn(input int k, input int p, input int a,
                           input logic [DW-1:0] wbv, input bit probe);
        predict(k, p, a, wbv);
        send_req(k, p, a, wbv);
        for (int i = 0; i < e_n; i++) begin
            get_msg();
            check(g_kind == e_kind[i] && g_dst == e_dst[i] && g_addr == a &&
                  (g_kind != 3 || g_data == e_data[i]), e_tag,
                  $sformatf("msg %0d: kind %0d dst %0d addr %0d data %h, expected kind %0d dst %0d addr %0d data %h",
                            i, g_kind, g_dst, g_addr, g_data, e_kind[i], e_dst[i], a, e_data[i]));
            if (g_kind == 1 || g_kind == 2) begin
                if (probe) probe_stall(a, p, g_dst);
                send_req(2, g_dst, a, wbv);
            end
        end
        #1;
        check(!out_valid && req_ready, e_tag,
              $sformatf("after transaction: out_valid %0d req_ready %0d, expected 0 1", out_valid, req_ready));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int b = 0; b < NBLK; b++) begin
            m_st[b] = 0; m_hold[b] = '0; m_mem[b] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!out_valid && req_ready, "R1",
              $sformatf("reset: out_valid %0d req_ready %0d, expected 0 1", out_valid, req_ready));

        // R1: block 0 starts uncached and zero, so a read returns 0
        run_txn(0, 1, 0, 16'h0000, 1'b0);
        check(g_data == '0, "R1", $sformatf("initial word %h expected 0000", g_data));
        run_txn(0, 3, 0, 16'h0000, 1'b0);      // R4
        run_txn(0, 0, 0, 16'h0000, 1'b0);      // R4
        run_txn(1, 1, 0, 16'h0000, 1'b0);      // R5: invalidate 0 then 3
        run_txn(0, 4, 0, 16'hbeef, 1'b1);      // R6 with stall probe
        run_txn(1, 4, 0, 16'h0000, 1'b0);      // R5: upgrade by a holder
        run_txn(1, 2, 0, 16'h1234, 1'b1);      // R7 with stall probe
        run_txn(2, 2, 0, 16'h5555, 1'b0);      // R8
        run_txn(0, 0, 0, 16'h0000, 1'b0);      // R2 after write-back
        run_txn(1, 0, 0, 16'h0000, 1'b0);      // R5: sole holder, reply only
        run_txn(1, 3, 1, 16'h0000, 1'b0);      // R3
        run_txn(0, 3, 1, 16'h0a0a, 1'b0);      // R6: owner reads its own block

        for (int n = 0; n < 400; n++) begin
            int k, p, a;
            logic [DW-1:0] v;
            k = $urandom_range(0, 2);
            p = $urandom_range(0, NPROC - 1);
            a = $urandom_range(0, NBLK - 1);
            v = DW'($urandom);
            if (k == 2) begin
                if (m_st[a] == 2) p = lowest(m_hold[a]);
                else k = 0;
            end
            run_txn(k, p, a, v, ($urandom_range(0, 3) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule